// File: doc/BRIEF.md
# Dual 256-Vector Pending and Active Tracker

This block keeps two 256-entry bitmaps of vector numbers. One is the request set, which records vectors that have been raised and not yet taken. The other is the in-service set, which records vectors that are currently being handled. Each bitmap is held as eight 32-bit words. A single set port and a single clear port each name one set and one 8-bit vector number, and each changes exactly one bit. A test port reports whether one named bit is present. Any 32-bit word of either set can be read.

For each set the block keeps a registered summary of the highest-numbered vector present. The search starts at the top word and works down to the first nonzero word, then takes that word's most significant set bit. When the set is empty the summary reads zero. The surrounding logic uses the two summaries to compare the best pending request against the best active one. That comparison is not part of this block.

Top module: `vtrk_tracker`

## Requirements
- R1: `rd_data` bit b equals the stored state of vector `rd_word`*32+b in the set chosen by `rd_sel` (0 = request set, 1 = in-service set). It is taken combinationally from the stored state.
- R2: When `set_en` is 1 at a rising edge, the bit for `set_vec` in the set chosen by `set_sel` becomes 1. Vector bits [7:5] pick the word and bits [4:0] pick the bit. No other bit in that set changes, except through a clear issued in the same cycle.
- R3: When `clr_en` is 1 at a rising edge, the bit for `clr_vec` in the set chosen by `clr_sel` becomes 0, unless R5 applies.
- R4: `tst_hit` equals the stored state of vector `tst_vec` in the set chosen by `tst_sel`. It is taken combinationally.
- R5: If a set and a clear name the same bit of the same set in one cycle, that bit ends up 1. If they name different bits, both take effect.
- R6: `req_top` and `srv_top` are registered. One edge after an array changes, each equals 32 times the highest nonzero word index plus the index of that word's most significant set bit.
- R7: An empty set gives a summary of 0.
- R8: A synchronous active-high `rst` clears both sets and both summaries.
- R9: A set or clear aimed at one set leaves every bit of the other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Set one bit |
| set_sel | input | 1 | Set target: 0 request, 1 in-service |
| set_vec | input | 8 | Vector to set |
| clr_en | input | 1 | Clear one bit |
| clr_sel | input | 1 | Clear target: 0 request, 1 in-service |
| clr_vec | input | 8 | Vector to clear |
| tst_sel | input | 1 | Test target set |
| tst_vec | input | 8 | Vector to test |
| tst_hit | output | 1 | Stored state of the tested bit |
| rd_sel | input | 1 | Read target set |
| rd_word | input | 3 | Word index to read |
| rd_data | output | 32 | Selected word |
| req_top | output | 8 | Highest vector in the request set |
| srv_top | output | 8 | Highest vector in the in-service set |

## Verification
The assertions check on every cycle that a set or clear lands on its named bit, that a set beats a clear of the same bit, and that the other set is left alone. They also check that each summary points at the highest bit of the array as it stood one edge earlier, and that it reads zero for an empty array. Some behaviours can only be shown by the bench's scenarios: the exact one-cycle lag of the summaries, the word and bit layout seen through the read and test ports, and word-boundary vectors such as 0, 31, 32 and 255 taking the lead as higher bits are cleared.

// File: rtl/vtrk_pkg.sv
package vtrk_pkg;
  localparam int NUM_SETS = 2;
  localparam logic SEL_REQ = 1'b0;
  localparam logic SEL_SRV = 1'b1;
endpackage

// File: rtl/vtrk_bitmap.sv
module vtrk_bitmap #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          set_en,
  input  logic [$clog2(WORDS*WORD_W)-1:0] set_vec,
  input  logic                          clr_en,
  input  logic [$clog2(WORDS*WORD_W)-1:0] clr_vec,
  input  logic [$clog2(WORDS*WORD_W)-1:0] tst_vec,
  input  logic [$clog2(WORDS)-1:0]      rd_word,
  output logic                          tst_bit,
  output logic [WORD_W-1:0]             rd_data,
  output logic [WORDS*WORD_W-1:0]       bits_flat
);
  localparam int TOTAL  = WORDS * WORD_W;
  localparam int VEC_W  = $clog2(TOTAL);
  localparam int BIT_W  = $clog2(WORD_W);

  logic [VEC_W-BIT_W-1:0] set_word, clr_word;
  logic [BIT_W-1:0]       set_bit, clr_bit;

  assign set_word = set_vec[VEC_W-1:BIT_W];
  assign set_bit  = set_vec[BIT_W-1:0];
  assign clr_word = clr_vec[VEC_W-1:BIT_W];
  assign clr_bit  = clr_vec[BIT_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] set_mask, clr_mask;

    always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (set_en && set_word == (VEC_W-BIT_W)'(w)) set_mask[set_bit] = 1'b1;
      if (clr_en && clr_word == (VEC_W-BIT_W)'(w)) clr_mask[clr_bit] = 1'b1;
    end

    // clear first, then set: a set of the same bit wins
    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= (word_q & ~clr_mask) | set_mask;
    end

    assign bits_flat[w*WORD_W +: WORD_W] = word_q;
  end

  assign rd_data = bits_flat[rd_word*WORD_W +: WORD_W];
  assign tst_bit = bits_flat[tst_vec];
endmodule

// File: rtl/vtrk_top_finder.sv
module vtrk_top_finder #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [WORDS*WORD_W-1:0]         bits_flat,
  output logic [$clog2(WORDS*WORD_W)-1:0] top_q
);
  localparam int VEC_W  = $clog2(WORDS * WORD_W);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WSEL_W = VEC_W - BIT_W;

  logic [WSEL_W-1:0] word_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [WORD_W-1:0] lead_word;

  // later (higher) words override earlier ones: same result as a top-down scan
  always_comb begin
    word_idx = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (|bits_flat[w*WORD_W +: WORD_W]) word_idx = WSEL_W'(w);
    end
    lead_word = bits_flat[word_idx*WORD_W +: WORD_W];
    bit_idx = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (lead_word[b]) bit_idx = BIT_W'(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) top_q <= '0;
    else     top_q <= {word_idx, bit_idx};
  end
endmodule

// File: rtl/vtrk_tracker.sv
module vtrk_tracker #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            set_en,
  input  logic                            set_sel,
  input  logic [$clog2(WORDS*WORD_W)-1:0] set_vec,
  input  logic                            clr_en,
  input  logic                            clr_sel,
  input  logic [$clog2(WORDS*WORD_W)-1:0] clr_vec,
  input  logic                            tst_sel,
  input  logic [$clog2(WORDS*WORD_W)-1:0] tst_vec,
  output logic                            tst_hit,
  input  logic                            rd_sel,
  input  logic [$clog2(WORDS)-1:0]        rd_word,
  output logic [WORD_W-1:0]               rd_data,
  output logic [$clog2(WORDS*WORD_W)-1:0] req_top,
  output logic [$clog2(WORDS*WORD_W)-1:0] srv_top
);
  import vtrk_pkg::*;
  localparam int TOTAL = WORDS * WORD_W;
  localparam int VEC_W = $clog2(TOTAL);

  logic [TOTAL-1:0]  bits_arr [NUM_SETS];
  logic [WORD_W-1:0] rd_arr   [NUM_SETS];
  logic              tst_arr  [NUM_SETS];
  logic [VEC_W-1:0]  top_arr  [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_here, clr_here;
    assign set_here = set_en && (set_sel == 1'(s));
    assign clr_here = clr_en && (clr_sel == 1'(s));

    vtrk_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_map (
      .clk       (clk),
      .rst       (rst),
      .set_en    (set_here),
      .set_vec   (set_vec),
      .clr_en    (clr_here),
      .clr_vec   (clr_vec),
      .tst_vec   (tst_vec),
      .rd_word   (rd_word),
      .tst_bit   (tst_arr[s]),
      .rd_data   (rd_arr[s]),
      .bits_flat (bits_arr[s])
    );

    vtrk_top_finder #(.WORDS(WORDS), .WORD_W(WORD_W)) u_top (
      .clk       (clk),
      .rst       (rst),
      .bits_flat (bits_arr[s]),
      .top_q     (top_arr[s])
    );
  end

  logic [TOTAL-1:0] req_bits, srv_bits;
  assign req_bits = bits_arr[SEL_REQ];
  assign srv_bits = bits_arr[SEL_SRV];

  assign tst_hit = tst_arr[tst_sel];
  assign rd_data = rd_arr[rd_sel];
  assign req_top = top_arr[SEL_REQ];
  assign srv_top = top_arr[SEL_SRV];
endmodule

// File: rtl/vtrk_tracker_chk.sv
module vtrk_tracker_chk #(
  parameter int TOTAL = 256,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             set_en,
  input logic             set_sel,
  input logic [VEC_W-1:0] set_vec,
  input logic             clr_en,
  input logic             clr_sel,
  input logic [VEC_W-1:0] clr_vec,
  input logic [TOTAL-1:0] req_bits,
  input logic [TOTAL-1:0] srv_bits,
  input logic [VEC_W-1:0] req_top,
  input logic [VEC_W-1:0] srv_top
);
  logic [TOTAL-1:0] prev_req, prev_srv;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_req <= '0;
      prev_srv <= '0;
    end else begin
      prev_req <= req_bits;
      prev_srv <= srv_bits;
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
    (set_en && !set_sel) |=> req_bits[$past(set_vec)]);  // R2
  AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !clr_sel && !(set_en && !set_sel && set_vec == clr_vec))
      |=> !req_bits[$past(clr_vec)]);  // R3
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    (set_en && clr_en && set_sel && clr_sel && set_vec == clr_vec)
      |=> srv_bits[$past(set_vec)]);  // R5
  AST_REQ_TOP_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    (prev_req != '0) |-> ((prev_req >> req_top) == TOTAL'(1)));  // R6
  AST_SRV_TOP_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    (prev_srv != '0) |-> ((prev_srv >> srv_top) == TOTAL'(1)));  // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req_bits == '0) |=> (req_top == '0));  // R7
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_bits == '0 && srv_bits == '0 && req_top == '0 && srv_top == '0));  // R8
  AST_OTHER_SET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(set_en && set_sel) && !(clr_en && clr_sel)) |=> $stable(srv_bits));  // R9
endmodule

bind vtrk_tracker vtrk_tracker_chk #(.TOTAL(WORDS*WORD_W), .VEC_W($clog2(WORDS*WORD_W))) u_chk (
  .clk      (clk),
  .rst      (rst),
  .set_en   (set_en),
  .set_sel  (set_sel),
  .set_vec  (set_vec),
  .clr_en   (clr_en),
  .clr_sel  (clr_sel),
  .clr_vec  (clr_vec),
  .req_bits (req_bits),
  .srv_bits (srv_bits),
  .req_top  (req_top),
  .srv_top  (srv_top)
);

// File: tb/vtrk_tracker_test.sv
`timescale 1ns/1ps
module vtrk_tracker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic set_en = 0, set_sel = 0, clr_en = 0, clr_sel = 0, tst_sel = 0, rd_sel = 0;
  logic [7:0] set_vec = 0, clr_vec = 0, tst_vec = 0;
  logic [2:0] rd_word = 0;
  logic tst_hit;
  logic [31:0] rd_data;
  logic [7:0] req_top, srv_top;

  int n_checks = 0;
  int n_errors = 0;
  logic [255:0] m_req = '0, m_srv = '0;

  always #10 clk = ~clk;

  vtrk_tracker uut (
    .clk(clk), .rst(rst),
    .set_en(set_en), .set_sel(set_sel), .set_vec(set_vec),
    .clr_en(clr_en), .clr_sel(clr_sel), .clr_vec(clr_vec),
    .tst_sel(tst_sel), .tst_vec(tst_vec), .tst_hit(tst_hit),
    .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
    .req_top(req_top), .srv_top(srv_top)
  );

  typedef struct packed {
    logic       se;
    logic       ss;
    logic [7:0] sv;
    logic       ce;
    logic       cs;
    logic [7:0] cv;
    logic [7:0] er;
    logic [7:0] es;
  } step_t;

  localparam int NSTEP = 12;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 1'b0, 8'd5,   1'b0, 1'b0, 8'd0,   8'd5,   8'd0},
    '{1'b1, 1'b0, 8'd200, 1'b0, 1'b0, 8'd0,   8'd200, 8'd0},
    '{1'b1, 1'b1, 8'd33,  1'b0, 1'b0, 8'd0,   8'd200, 8'd33},
    '{1'b1, 1'b0, 8'd255, 1'b0, 1'b0, 8'd0,   8'd255, 8'd33},
    '{1'b0, 1'b0, 8'd0,   1'b1, 1'b0, 8'd255, 8'd200, 8'd33},
    '{1'b1, 1'b1, 8'd31,  1'b1, 1'b0, 8'd200, 8'd5,   8'd33},
    '{1'b0, 1'b0, 8'd0,   1'b1, 1'b1, 8'd33,  8'd5,   8'd31},
    '{1'b1, 1'b0, 8'd0,   1'b1, 1'b0, 8'd5,   8'd0,   8'd31},
    '{1'b1, 1'b1, 8'd64,  1'b1, 1'b1, 8'd64,  8'd0,   8'd64},
    '{1'b0, 1'b0, 8'd0,   1'b1, 1'b1, 8'd64,  8'd0,   8'd31},
    '{1'b1, 1'b0, 8'd96,  1'b1, 1'b1, 8'd31,  8'd96,  8'd0},
    '{1'b1, 1'b0, 8'd127, 1'b0, 1'b0, 8'd0,   8'd127, 8'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model: clear, then set, so a same-bit set wins (R5)
  task automatic model_apply(input step_t s);
    if (s.ce) begin
      if (s.cs) m_srv[s.cv] = 1'b0; else m_req[s.cv] = 1'b0;
    end
    if (s.se) begin
      if (s.ss) m_srv[s.sv] = 1'b1; else m_req[s.sv] = 1'b1;
    end
  endtask

  task automatic check_words(input string req);
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 8; w++) begin
        logic [31:0] exp;
        rd_sel = 1'(s);
        rd_word = 3'(w);
        #0.2;
        exp = s ? m_srv[w*32 +: 32] : m_req[w*32 +: 32];
        check(rd_data === exp, req, rd_data, exp);
      end
    end
  endtask

  task automatic check_bit(input logic sel, input logic [7:0] vec, input string req);
    logic exp;
    tst_sel = sel;
    tst_vec = vec;
    #0.2;
    exp = sel ? m_srv[vec] : m_req[vec];
    check(tst_hit === exp, req, tst_hit, exp);
  endtask

  // drive at a falling edge; array changes at the next rising edge,
  // summary one rising edge later
  task automatic run_step(input step_t s, input bit check_lag);
    @(negedge clk);
    set_en = s.se; set_sel = s.ss; set_vec = s.sv;
    clr_en = s.ce; clr_sel = s.cs; clr_vec = s.cv;
    @(negedge clk);
    set_en = 0; clr_en = 0;
    if (check_lag) begin
      check(req_top !== s.er, "R6 lag", req_top, 32'(s.er));
    end
    model_apply(s);
    if (s.se) check_bit(s.ss, s.sv, "R2/R5 set bit");
    if (s.ce && !(s.se && s.ss == s.cs && s.sv == s.cv)) check_bit(s.cs, s.cv, "R3 cleared bit");
    check_words("R1/R9 words");
    @(negedge clk);
    check(req_top === s.er, "R6/R7 req_top", req_top, 32'(s.er));
    check(srv_top === s.es, "R6/R7 srv_top", srv_top, 32'(s.es));
  endtask

  initial begin
    #(20.0 * 200000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8: reset state
    check(req_top === 8'd0, "R8 req_top", req_top, 0);
    check(srv_top === 8'd0, "R8 srv_top", srv_top, 0);
    check_words("R8 words");
    // R7: empty sets report 0
    @(negedge clk);
    check(req_top === 8'd0 && srv_top === 8'd0, "R7 empty", {req_top, srv_top}, 0);

    for (int i = 0; i < NSTEP; i++) run_step(TBL[i], 1'b0);

    // R6: summary moves only one edge after the array change
    run_step('{1'b1, 1'b0, 8'd250, 1'b0, 1'b0, 8'd0, 8'd250, 8'd0}, 1'b1);
    // R5: both a set and a clear of different bits in the same set take effect
    run_step('{1'b1, 1'b0, 8'd32, 1'b1, 1'b0, 8'd250, 8'd127, 8'd0}, 1'b1);
    // R4: test port on neighbours of word boundaries
    check_bit(1'b0, 8'd31, "R4 vec31 clear");
    check_bit(1'b0, 8'd32, "R4 vec32 set");
    check_bit(1'b1, 8'd32, "R4/R9 other set");
    // R7: empty the request set again
    run_step('{1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 8'd127, 8'd96, 8'd0}, 1'b0);
    run_step('{1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 8'd96,  8'd32, 8'd0}, 1'b0);
    run_step('{1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 8'd32,  8'd0,  8'd0}, 1'b0);
    run_step('{1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 8'd0,   8'd0,  8'd0}, 1'b0);
    check(m_req == '0, "R7 model empty", 0, 0);

    // R8: reset mid-run with contents present
    run_step('{1'b1, 1'b1, 8'd128, 1'b0, 1'b0, 8'd0, 8'd0, 8'd128}, 1'b0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    m_req = '0;
    m_srv = '0;
    check(srv_top === 8'd0, "R8 srv_top after reset", srv_top, 0);
    check_words("R8 words after reset");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule